// File: doc/BRIEF.md
# Interleaved Two-Step Program Sequencer

This block orders program operations for one multi-level flash block. Each wordline stores a low page (LSB) and a high page (MSB). A wordline is written in two steps. The LSB step leaves the cells partially programmed, and the MSB step brings them to their final levels. The steps of neighbouring wordlines are staggered, so the final step of a wordline always follows the first step of the wordline above it.

A host asks for one page write at a time by naming a wordline and a page type. The sequencer holds a step pointer and a two-bit state for every wordline. A request that matches the next legal step becomes a program command one cycle later. Any other request raises an error pulse and changes nothing. An erase request returns every wordline to the erased state and moves the pointer back to the start. The per-wordline status is exported as a flat vector for the read-voltage logic.

Top module: `prog_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every wordline reads erased, `cmd_valid`, `err` and `seq_done` are low.
- R2: Only this page order is accepted: LSB of wordline 0, LSB of 1, MSB of 0, LSB of 2, MSB of 1, and so on. The order ends with LSB of N-1, MSB of N-2 and MSB of N-1, which gives 2N steps in total.
- R3: The MSB step of wordline n (n < N-1) is accepted only after the LSB step of wordline n+1 has been accepted. The last wordline's MSB needs no following LSB.
- R4: An accepted request gives, on the next cycle, `cmd_valid`=1 with `cmd_op`=2'b01 (program), `cmd_wl` equal to the requested wordline and `cmd_msb` equal to the requested page type (0 = LSB, 1 = MSB).
- R5: `wl_state[2w+1:2w]` gives the state of wordline w: 2'b00 erased, 2'b01 partially programmed (LSB only), 2'b11 fully programmed. The value is updated in the same cycle as the matching command.
- R6: A request that is not the next legal step gives `err`=1 on the next cycle, with `cmd_valid`=0 and `wl_state` unchanged. A request naming a wordline index of N or more is also out of order.
- R7: After the final MSB step, `seq_done` is 1 and every further request is rejected as in R6.
- R8: An erase request gives, on the next cycle, `cmd_valid`=1 with `cmd_op`=2'b10, `cmd_wl`=0 and `cmd_msb`=0. All wordline states become erased, `seq_done` goes low and the pointer returns to LSB of wordline 0. Erase takes priority over a request in the same cycle, and that request is dropped without an error.
- R9: A wordline state never shows 2'b10 and never goes down, except through an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Page program request strobe |
| req_wl | input | WLW | Requested wordline |
| req_msb | input | 1 | Requested page type, 1 = MSB |
| erase_req | input | 1 | Block erase request |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 01 program, 10 erase |
| cmd_wl | output | WLW | Command wordline |
| cmd_msb | output | 1 | Command page type |
| err | output | 1 | Out-of-order request rejected |
| seq_done | output | 1 | All pages of the block programmed |
| wl_state | output | 2*NUM_WL | Per-wordline state, two bits each |

## Verification
The assertions assume that each request lasts a single cycle and that reset is held long enough to clear the registers. They tie each command to the state vector it produces. An MSB command must find the wordline above it already holding its LSB, and a rejection must leave the state vector frozen. The stimulus pulses every request for exactly one cycle. At every step of a four-wordline block it offers each wrong wordline and page pair before the legal one. It then erases from the middle of the sequence and from the completed sequence, and once together with a legal request.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int NUM_WL = 8,
  localparam int WLW = (NUM_WL > 1) ? $clog2(NUM_WL) : 1,
  localparam int PW = $clog2(2 * NUM_WL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [WLW-1:0]        req_wl,
  input  logic                  req_msb,
  input  logic                  erase_req,
  output logic                  cmd_valid,
  output logic [1:0]            cmd_op,
  output logic [WLW-1:0]        cmd_wl,
  output logic                  cmd_msb,
  output logic                  err,
  output logic                  seq_done,
  output logic [2*NUM_WL-1:0]   wl_state
);
  localparam logic [PW-1:0] LAST_P = PW'(2 * NUM_WL - 1);
  localparam logic [PW-1:0] DONE_P = PW'(2 * NUM_WL);
  localparam logic [1:0] OP_PROG = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;

  logic [PW-1:0]  ptr;
  logic [PW-1:0]  half_up, half_dn;
  logic [WLW-1:0] exp_wl;
  logic           exp_msb;
  logic           hit;

  assign half_up = (ptr + PW'(1)) >> 1;
  assign half_dn = (ptr >> 1) - PW'(1);

  always_comb begin
    if (ptr == '0) begin
      exp_wl  = '0;
      exp_msb = 1'b0;
    end else if (ptr == LAST_P) begin
      exp_wl  = WLW'(NUM_WL - 1);
      exp_msb = 1'b1;
    end else if (ptr[0]) begin
      exp_wl  = half_up[WLW-1:0];
      exp_msb = 1'b0;
    end else begin
      exp_wl  = half_dn[WLW-1:0];
      exp_msb = 1'b1;
    end
  end

  assign seq_done = (ptr == DONE_P);
  assign hit = req_valid && !seq_done && (req_wl == exp_wl) && (req_msb == exp_msb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= 2'b00;
      cmd_wl    <= '0;
      cmd_msb   <= 1'b0;
      err       <= 1'b0;
    end else begin
      cmd_valid <= erase_req || hit;
      err       <= !erase_req && req_valid && !hit;
      if (erase_req) begin
        ptr     <= '0;
        cmd_op  <= OP_ERASE;
        cmd_wl  <= '0;
        cmd_msb <= 1'b0;
      end else if (hit) begin
        ptr     <= ptr + PW'(1);
        cmd_op  <= OP_PROG;
        cmd_wl  <= req_wl;
        cmd_msb <= req_msb;
      end
    end
  end

  for (genvar w = 0; w < NUM_WL; w++) begin : g_wl
    logic [1:0] st;
    always_ff @(posedge clk) begin
      if (!rst_n || erase_req)
        st <= 2'b00;
      else if (hit && req_wl == WLW'(w))
        st <= req_msb ? 2'b11 : 2'b01;
    end
    assign wl_state[2*w +: 2] = st;
  end
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int NUM_WL = 8,
  localparam int WLW = (NUM_WL > 1) ? $clog2(NUM_WL) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [1:0]          cmd_op,
  input logic [WLW-1:0]      cmd_wl,
  input logic                cmd_msb,
  input logic                err,
  input logic                seq_done,
  input logic [2*NUM_WL-1:0] wl_state
);
  // R3
  msb_after_upper_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && cmd_msb && int'(cmd_wl) != NUM_WL - 1)
      |-> wl_state[2*int'(cmd_wl)+2 +: 2] != 2'b00);

  // R4
  lsb_cmd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && !cmd_msb) |-> wl_state[2*int'(cmd_wl) +: 2] == 2'b01);

  // R4
  msb_cmd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && cmd_msb) |-> wl_state[2*int'(cmd_wl) +: 2] == 2'b11);

  // R6
  reject_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(wl_state) && !cmd_valid));

  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (&wl_state));

  // R8
  erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |-> (wl_state == '0 && !seq_done && !err));

  for (genvar w = 0; w < NUM_WL; w++) begin : g_mono
    // R9
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wl_state[2*w +: 2] != 2'b10);
    // R9
    state_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_op == 2'b10) |-> wl_state[2*w +: 2] >= $past(wl_state[2*w +: 2]));
  end
endmodule

bind prog_seq prog_seq_chk #(.NUM_WL(NUM_WL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_wl(cmd_wl), .cmd_msb(cmd_msb), .err(err), .seq_done(seq_done),
  .wl_state(wl_state)
);

// File: tb/prog_seq_tb.sv
module prog_seq_tb;
  localparam int N = 4;
  localparam int WLW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [WLW-1:0] req_wl = '0;
  logic req_msb = 1'b0;
  logic erase_req = 1'b0;
  logic cmd_valid, cmd_msb, err, seq_done;
  logic [1:0] cmd_op;
  logic [WLW-1:0] cmd_wl;
  logic [2*N-1:0] wl_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prog_seq #(.NUM_WL(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wl(req_wl),
    .req_msb(req_msb), .erase_req(erase_req), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wl(cmd_wl), .cmd_msb(cmd_msb), .err(err),
    .seq_done(seq_done), .wl_state(wl_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step_wl(input int k);
    if (k == 0) return 0;
    if (k == 2*N-1) return N-1;
    if (k % 2 == 1) return (k+1)/2;
    return k/2 - 1;
  endfunction

  function automatic bit step_msb(input int k);
    if (k == 0) return 0;
    if (k == 2*N-1) return 1;
    return (k % 2 == 0);
  endfunction

  function automatic logic [2*N-1:0] stat_exp(input int k);
    logic [2*N-1:0] s = '0;
    for (int w = 0; w < N; w++) begin
      int li = (w == 0) ? 0 : 2*w - 1;
      int mi = (w == N-1) ? 2*N-1 : 2*w + 2;
      if (mi < k) s[2*w +: 2] = 2'b11;
      else if (li < k) s[2*w +: 2] = 2'b01;
    end
    return s;
  endfunction

  task automatic drive(input int wl, input bit msb, input bit valid, input bit ers);
    @(negedge clk);
    req_valid = valid;
    req_wl = WLW'(wl);
    req_msb = msb;
    erase_req = ers;
    @(negedge clk);
    req_valid = 1'b0;
    erase_req = 1'b0;
  endtask

  task automatic expect_reject(input int k, input string req);
    chk(err == 1'b1, req, int'(err), 1);
    chk(cmd_valid == 1'b0, req, int'(cmd_valid), 0);
    chk(wl_state == stat_exp(k), req, int'(wl_state), int'(stat_exp(k)));
  endtask

  task automatic expect_accept(input int k);
    int w = step_wl(k);
    bit m = step_msb(k);
    chk(cmd_valid == 1'b1, "R4", int'(cmd_valid), 1);
    chk(cmd_op == 2'b01, "R4", int'(cmd_op), 1);
    chk(int'(cmd_wl) == w, "R2", int'(cmd_wl), w);
    chk(cmd_msb == m, "R2", int'(cmd_msb), int'(m));
    chk(err == 1'b0, "R2", int'(err), 0);
    chk(wl_state == stat_exp(k+1), "R5", int'(wl_state), int'(stat_exp(k+1)));
    if (m && w < N-1)
      chk(wl_state[2*w+2 +: 2] != 2'b00, "R3", int'(wl_state[2*w+2 +: 2]), 1);
    for (int v = 0; v < N; v++)
      chk(wl_state[2*v +: 2] != 2'b10, "R9", int'(wl_state[2*v +: 2]), 0);
  endtask

  task automatic expect_erase(input string req);
    chk(cmd_valid == 1'b1, req, int'(cmd_valid), 1);
    chk(cmd_op == 2'b10, req, int'(cmd_op), 2);
    chk(cmd_wl == '0 && cmd_msb == 1'b0, req, int'(cmd_wl), 0);
    chk(wl_state == '0, req, int'(wl_state), 0);
    chk(seq_done == 1'b0, req, int'(seq_done), 0);
    chk(err == 1'b0, req, int'(err), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(wl_state == '0 && !cmd_valid && !err && !seq_done, "R1", int'(wl_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wl_state == '0 && !cmd_valid && !err && !seq_done, "R1", int'(wl_state), 0);

    // R2, R3, R6: every wrong pair at every step, then the legal one
    for (int k = 0; k < 2*N; k++) begin
      for (int w = 0; w < N; w++) begin
        for (int m = 0; m < 2; m++) begin
          if (!(w == step_wl(k) && m == int'(step_msb(k)))) begin
            drive(w, m[0], 1'b1, 1'b0);
            expect_reject(k, (m == 1) ? "R3" : "R6");
          end
        end
      end
      drive(step_wl(k), step_msb(k), 1'b1, 1'b0);
      expect_accept(k);
      chk(seq_done == (k == 2*N-1), "R7", int'(seq_done), int'(k == 2*N-1));
    end

    // R7: anything after completion is rejected
    drive(0, 1'b0, 1'b1, 1'b0);
    expect_reject(2*N, "R7");
    drive(N-1, 1'b1, 1'b1, 1'b0);
    expect_reject(2*N, "R7");

    // R8: erase from completed block
    drive(0, 1'b0, 1'b0, 1'b1);
    expect_erase("R8");

    // R8: erase mid-sequence together with a legal request
    for (int k = 0; k < 3; k++) begin
      drive(step_wl(k), step_msb(k), 1'b1, 1'b0);
      expect_accept(k);
    end
    drive(step_wl(3), step_msb(3), 1'b1, 1'b1);
    expect_erase("R8");

    // R8: pointer back at start
    drive(0, 1'b0, 1'b1, 1'b0);
    expect_accept(0);
    // R3: MSB of wordline 0 before LSB of wordline 1
    drive(0, 1'b1, 1'b1, 1'b0);
    expect_reject(1, "R3");
    drive(1, 1'b0, 1'b1, 1'b0);
    expect_accept(1);
    drive(0, 1'b1, 1'b1, 1'b0);
    expect_accept(2);

    @(negedge clk);
    summary();
  end
endmodule